// File: doc/BRIEF.md
# Double-buffered UART transmitter

This block turns bytes into asynchronous serial frames. A one-character holding register sits in front of a frame shift register. Software can queue the next character while the current one is still being shifted out, so consecutive frames leave the line with no idle gap. Characters are 8 bits, or 9 bits when the ninth-bit mode is selected. In that mode the extra bit comes from a separate input and can act as a parity bit or as a second stop bit.

The bit period is counted in ticks from an external baud tick input: 16 ticks per bit, or 8 when double speed is selected. The block reports two flags, holding-register empty and transmission complete. Each flag drives an interrupt request through its own enable.

Clearing the transmit enable refuses further writes but does not cut off the line. The character in the shift register and any character already waiting in the holding register are both sent in full. Only then does the line rest high.

Top module: `uart_tx_dbuf`

## Requirements
- R1: The line rests at 1 when nothing is being sent. A frame is a 0 start bit, then the data bits least significant first, then a 1 stop bit.
- R2: With `nine_bit_i` = 1, the frame carries an extra bit equal to the written `wr_bit8_i`, placed between the last data bit and the stop bit (11 bits in total). With `nine_bit_i` = 0 the frame is 10 bits.
- R3: Each bit lasts 16 baud ticks, or 8 when `dbl_speed_i` = 1. Both mode inputs are captured when a character enters the shift register, and later changes do not affect that frame.
- R4: `dre_o` is 1 after reset. It falls on the clock edge that accepts a write. It rises on the edge that moves the held character into the shift register, and the start bit begins on that same edge.
- R5: A write is accepted only while `dre_o` = 1 and `tx_en_i` = 1. Any other write is ignored and changes no output.
- R6: A character held when a stop bit ends starts its start bit on the very next bit boundary, with no idle cycle in between.
- R7: `txc_o` sets when a stop bit ends and no character is held. It clears on an accepted write or on `txc_ack_i`. An accepted write overrides setting, and setting overrides the acknowledge.
- R8: `dre_irq_o` equals `dre_o` AND `dre_ie_i`, and `txc_irq_o` equals `txc_o` AND `txc_ie_i`.
- R9: After `tx_en_i` falls, the character in the shift register and the one in the holding register are both sent completely, and then the line rests high.
- R10: After reset, `txd_o` = 1 and `txc_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_en_i | input | 1 | Transmit enable; gates writes, drains gracefully when low |
| nine_bit_i | input | 1 | Selects 9-bit characters |
| dbl_speed_i | input | 1 | Selects 8 ticks per bit instead of 16 |
| tick_i | input | 1 | Baud tick, one clock wide |
| wr_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | DATA_W | Character data |
| wr_bit8_i | input | 1 | Ninth bit for 9-bit characters |
| txc_ack_i | input | 1 | Clears the transmission-complete flag |
| dre_ie_i | input | 1 | Enable for the empty-register interrupt |
| txc_ie_i | input | 1 | Enable for the complete interrupt |
| txd_o | output | 1 | Serial output |
| dre_o | output | 1 | Holding register empty |
| txc_o | output | 1 | Transmission complete |
| dre_irq_o | output | 1 | Empty-register interrupt request |
| txc_irq_o | output | 1 | Complete interrupt request |

## Verification
If a write is accepted on edge N, `dre_o` is low after N. The shift register loads on edge N+1, and after that edge `dre_o` is high again and the start bit is on the line. With the tick held high, bit k occupies the cycles from edge N+1+k·P up to edge N+1+(k+1)·P, where P is 16 or 8. `txc_o` sets on edge N+1+F·P, where F is the frame length, and a held character starts on that same edge; the interrupt outputs follow their flags within the same cycle. The bench keeps a count of clock edges and derives each expected edge from it. It samples the serial line at the falling edge nearest each bit's middle, and samples the flags on the falling edges just before and just after the edge where they are due, so a result that is one cycle early or late is caught.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic {
    SH_IDLE = 1'b0,
    SH_SEND = 1'b1
  } sh_state_e;

  // Longest frame: start + data + ninth bit + stop
  function automatic int frame_bits(int data_w);
    return data_w + 3;
  endfunction

endpackage

// File: rtl/tx_rst_sync.sv
module tx_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/tx_hold.sv
module tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              bit8_i,
  input  logic              take_i,
  output logic              acc_o,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o,
  output logic              bit8_o
);
  logic              full_q, full_n;
  logic [DATA_W-1:0] data_q;
  logic              bit8_q;

  assign acc_o = wr_i & en_i & ~full_q;

  always_comb begin
    full_n = full_q;
    if (take_i)     full_n = 1'b0;
    else if (acc_o) full_n = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) full_q <= 1'b0;
    else         full_q <= full_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      bit8_q <= 1'b0;
    end else if (acc_o) begin
      data_q <= data_i;
      bit8_q <= bit8_i;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
  assign bit8_o = bit8_q;
endmodule

// File: rtl/tx_baud.sv
module tx_baud #(
  parameter int OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  input  logic dbl_i,
  input  logic tick_i,
  output logic bit_end_o
);
  localparam int CW = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] LIM_NORM = CW'(OVS - 1);
  localparam logic [CW-1:0] LIM_DBL  = CW'(OVS / 2 - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic [CW-1:0] lim;
  logic          cnt_en;

  assign lim       = dbl_i ? LIM_DBL : LIM_NORM;
  assign bit_end_o = run_i & tick_i & (cnt_q == lim);
  assign cnt_en    = restart_i | (run_i & tick_i);

  always_comb begin
    if (restart_i || bit_end_o) cnt_n = '0;
    else                        cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end
endmodule

// File: rtl/tx_shift.sv
module tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              bit8_i,
  input  logic              nine_i,
  input  logic              dbl_i,
  input  logic              bit_end_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              dbl_o,
  output logic              txd_o
);
  localparam int FRM_W = frame_bits(DATA_W);
  localparam int LW    = $clog2(FRM_W + 1);

  sh_state_e        st_q, st_n;
  logic [FRM_W-1:0] sh_q, sh_n;
  logic [LW-1:0]    left_q, left_n;
  logic             dbl_q, dbl_n;
  logic             upd;
  logic             bit8_or_stop;

  assign busy_o       = (st_q == SH_SEND);
  assign done_o       = busy_o & bit_end_i & (left_q == LW'(1));
  assign upd          = load_i | (busy_o & bit_end_i);
  assign bit8_or_stop = nine_i ? bit8_i : 1'b1;

  always_comb begin
    st_n   = st_q;
    sh_n   = sh_q;
    left_n = left_q;
    dbl_n  = dbl_q;
    if (load_i) begin
      st_n   = SH_SEND;
      sh_n   = {1'b1, bit8_or_stop, data_i, 1'b0};
      left_n = nine_i ? LW'(FRM_W) : LW'(FRM_W - 1);
      dbl_n  = dbl_i;
    end else if (busy_o && bit_end_i) begin
      sh_n   = {1'b1, sh_q[FRM_W-1:1]};
      left_n = left_q - 1'b1;
      if (left_q == LW'(1)) st_n = SH_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SH_IDLE;
      sh_q   <= '1;
      left_q <= '0;
      dbl_q  <= 1'b0;
    end else if (upd) begin
      st_q   <= st_n;
      sh_q   <= sh_n;
      left_q <= left_n;
      dbl_q  <= dbl_n;
    end
  end

  assign dbl_o = dbl_q;
  assign txd_o = busy_o ? sh_q[0] : 1'b1;
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              nine_bit_i,
  input  logic              dbl_speed_i,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_bit8_i,
  input  logic              txc_ack_i,
  input  logic              dre_ie_i,
  input  logic              txc_ie_i,
  output logic              txd_o,
  output logic              dre_o,
  output logic              txc_o,
  output logic              dre_irq_o,
  output logic              txc_irq_o
);
  logic              rst_n;
  logic              acc, full, load;
  logic [DATA_W-1:0] hold_data;
  logic              hold_bit8;
  logic              busy, done, dbl_act, bit_end;
  logic              txc_q, txc_n;

  tx_rst_sync u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n)
  );

  tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .wr_i  (wr_i),
    .en_i  (tx_en_i),
    .data_i(wr_data_i),
    .bit8_i(wr_bit8_i),
    .take_i(load),
    .acc_o (acc),
    .full_o(full),
    .data_o(hold_data),
    .bit8_o(hold_bit8)
  );

  // Held character moves in when the shifter is idle or finishing a stop bit
  assign load = full & (~busy | done);

  tx_baud #(.OVS(OVS)) u_baud (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .run_i    (busy),
    .restart_i(load),
    .dbl_i    (dbl_act),
    .tick_i   (tick_i),
    .bit_end_o(bit_end)
  );

  tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .load_i   (load),
    .data_i   (hold_data),
    .bit8_i   (hold_bit8),
    .nine_i   (nine_bit_i),
    .dbl_i    (dbl_speed_i),
    .bit_end_i(bit_end),
    .busy_o   (busy),
    .done_o   (done),
    .dbl_o    (dbl_act),
    .txd_o    (txd_o)
  );

  always_comb begin
    txc_n = txc_q;
    if (acc)                txc_n = 1'b0;
    else if (done && !full) txc_n = 1'b1;
    else if (txc_ack_i)     txc_n = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) txc_q <= 1'b0;
    else        txc_q <= txc_n;
  end

  assign dre_o     = ~full;
  assign txc_o     = txc_q;
  assign dre_irq_o = dre_o & dre_ie_i;
  assign txc_irq_o = txc_q & txc_ie_i;
endmodule

// File: rtl/tx_dbuf_chk.sv
module tx_dbuf_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_en_i,
  input logic wr_i,
  input logic dre_ie_i,
  input logic txc_ie_i,
  input logic txd_o,
  input logic dre_o,
  input logic txc_o,
  input logic dre_irq_o,
  input logic txc_irq_o
);
  AST_WR_TAKES_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && tx_en_i && dre_o |=> !dre_o); // R4
  AST_LOAD_STARTS_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dre_o) |-> !txd_o); // R6
  AST_DISABLED_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i && dre_o |=> dre_o); // R5
  AST_WR_CLEARS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && tx_en_i && dre_o |=> !txc_o); // R7
  AST_DONE_MEANS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txc_o |-> txd_o && dre_o); // R1
  AST_DONE_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txc_o) |-> $past(txd_o)); // R7
  AST_DRE_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dre_irq_o |-> dre_o && dre_ie_i); // R8
  AST_TXC_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txc_irq_o |-> txc_o && txc_ie_i); // R8
endmodule

bind uart_tx_dbuf tx_dbuf_chk chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tx_en_i  (tx_en_i),
  .wr_i     (wr_i),
  .dre_ie_i (dre_ie_i),
  .txc_ie_i (txc_ie_i),
  .txd_o    (txd_o),
  .dre_o    (dre_o),
  .txc_o    (txc_o),
  .dre_irq_o(dre_irq_o),
  .txc_irq_o(txc_irq_o)
);

// File: tb/uart_tx_dbuf_tb_top.sv
module uart_tx_dbuf_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, tx_en, nine, dbl, tick, wr, wr_b8, ack, dre_ie, txc_ie;
  logic [7:0] wr_data;
  logic       txd, dre, txc, dre_irq, txc_irq;
  int         cyc = 0;
  int         total = 0;
  int         bad = 0;
  bit         finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_tx_dbuf #(.DATA_W(8), .OVS(16)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .nine_bit_i(nine),
    .dbl_speed_i(dbl), .tick_i(tick), .wr_i(wr), .wr_data_i(wr_data),
    .wr_bit8_i(wr_b8), .txc_ack_i(ack), .dre_ie_i(dre_ie), .txc_ie_i(txc_ie),
    .txd_o(txd), .dre_o(dre), .txc_o(txc), .dre_irq_o(dre_irq), .txc_irq_o(txc_irq)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Write accepted (or refused) on edge n_edge; returns at the falling edge after it
  task automatic put(logic [7:0] d, logic b8, output int n_edge);
    @(negedge clk);
    wr_data = d; wr_b8 = b8; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    n_edge = cyc;
  endtask

  function automatic logic [10:0] exp_frame(logic [7:0] d, logic b8, logic nb);
    logic [10:0] f;
    f = '1;
    f[0] = 1'b0;
    f[8:1] = d;
    if (nb) f[9] = b8;
    return f;
  endfunction

  task automatic sample_frame(int l_edge, int n, int div, output logic [10:0] got);
    got = '1;
    for (int k = 0; k < n; k++) begin
      wait_until(l_edge + k * div + div / 2);
      got[k] = txd;
    end
  endtask

  // Interrupt outputs under all four enable patterns, for known flag values
  task automatic irq_sweep(logic exp_dre, logic exp_txc);
    for (int ie = 0; ie < 4; ie++) begin
      dre_ie = ie[0]; txc_ie = ie[1];
      #1;
      check("R8 dre_irq", int'(dre_irq), int'(exp_dre & ie[0]));
      check("R8 txc_irq", int'(txc_irq), int'(exp_txc & ie[1]));
    end
  endtask

  initial begin
    int          na, nb, nc, d1, d2;
    logic [10:0] got;
    rst_n = 1'b0; tx_en = 1'b1; nine = 1'b0; dbl = 1'b0; tick = 1'b1;
    wr = 1'b0; wr_b8 = 1'b0; wr_data = '0; ack = 1'b0; dre_ie = 1'b1; txc_ie = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 / R4 reset state
    check("R10 txd idle", int'(txd), 1);
    check("R10 txc reset", int'(txc), 0);
    check("R4 dre reset", int'(dre), 1);
    check("R8 dre_irq reset", int'(dre_irq), 1);
    check("R8 txc_irq reset", int'(txc_irq), 0);

    // R1 R2 R3 sweep over every mode
    for (int m = 0; m < 4; m++) begin
      int n, div, step;
      nine = m[0]; dbl = m[1];
      n = nine ? 11 : 10;
      div = dbl ? 8 : 16;
      step = nine ? 5 : 1;
      for (int d = 0; d < 256; d += step) begin
        logic b8;
        b8 = logic'((d % 3) == 0);
        put(8'(d), b8, na);
        check("R4 dre after write", int'(dre), 0);
        sample_frame(na + 1, n, div, got);
        check(nine ? "R2 frame 9-bit" : "R1 frame 8-bit", int'(got), int'(exp_frame(8'(d), b8, nine)));
        wait_until(na + n * div);
        check("R3 no early end", int'(txc), 0);
        wait_until(na + 1 + n * div);
        check("R3 R7 txc at frame end", int'(txc), 1);
        check("R1 idle after frame", int'(txd), 1);
      end
    end
    nine = 1'b0; dbl = 1'b0;

    // R6 back-to-back, R5 write to full holding register ignored
    put(8'h3C, 1'b0, na);
    put(8'hC5, 1'b0, nb);
    check("R4 holding full", int'(dre), 0);
    put(8'hFF, 1'b0, nc);
    irq_sweep(1'b0, 1'b0);
    sample_frame(na + 1, 10, 16, got);
    check("R6 first frame", int'(got), int'(exp_frame(8'h3C, 1'b0, 1'b0)));
    d1 = na + 1 + 160;
    wait_until(d1);
    check("R6 no txc between frames", int'(txc), 0);
    check("R6 start bit without gap", int'(txd), 0);
    sample_frame(d1, 10, 16, got);
    check("R6 second frame", int'(got), int'(exp_frame(8'hC5, 1'b0, 1'b0)));
    wait_until(d1 + 160);
    check("R7 txc after second", int'(txc), 1);
    wait_until(d1 + 200);
    check("R5 refused write not sent", int'(txd), 1);
    check("R5 refused write left empty", int'(dre), 1);
    irq_sweep(1'b1, 1'b1);

    // R3 mode captured at load
    put(8'h96, 1'b0, na);
    wait_until(na + 2);
    dbl = 1'b1; nine = 1'b1;
    sample_frame(na + 1, 10, 16, got);
    check("R3 mode held during frame", int'(got), int'(exp_frame(8'h96, 1'b0, 1'b0)));
    wait_until(na + 161);
    check("R3 frame length held", int'(txc), 1);
    dbl = 1'b0; nine = 1'b0;

    // R9 graceful disable drains both characters
    put(8'hA7, 1'b0, na);
    put(8'h19, 1'b0, nb);
    tx_en = 1'b0;
    sample_frame(na + 1, 10, 16, got);
    check("R9 shifting char sent", int'(got), int'(exp_frame(8'hA7, 1'b0, 1'b0)));
    d2 = na + 1 + 160;
    sample_frame(d2, 10, 16, got);
    check("R9 held char sent", int'(got), int'(exp_frame(8'h19, 1'b0, 1'b0)));
    wait_until(d2 + 160);
    check("R9 txc after drain", int'(txc), 1);
    wait_until(d2 + 190);
    check("R9 line idle after drain", int'(txd), 1);
    put(8'h00, 1'b0, nc);
    check("R5 disabled write ignored dre", int'(dre), 1);
    check("R5 disabled write keeps txc", int'(txc), 1);
    wait_until(nc + 40);
    check("R5 disabled write not sent", int'(txd), 1);
    tx_en = 1'b1;

    // R7 acknowledge, set beats acknowledge, write clears
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    check("R7 ack clears", int'(txc), 0);
    irq_sweep(1'b1, 1'b0);
    ack = 1'b1;
    put(8'h5A, 1'b0, na);
    wait_until(na + 161);
    check("R7 set wins over ack", int'(txc), 1);
    wait_until(na + 162);
    check("R7 ack clears next", int'(txc), 0);
    ack = 1'b0;
    put(8'h01, 1'b0, na);
    wait_until(na + 161);
    check("R7 set again", int'(txc), 1);
    put(8'h02, 1'b0, nb);
    check("R7 write clears txc", int'(txc), 0);
    wait_until(nb + 165);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R1 act=%0d exp=0", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule